// File: doc/BRIEF.md
# Grouped-Word Single-Error-Correcting Byte Memory Wrapper

This block gives a byte-wide read/write port onto a storage array whose words each hold four bytes plus six check bits. A byte address selects one stored word: the word index is the byte address with its two low bits removed, and those two bits pick the byte lane. Reads fetch the whole word, repair any single flipped bit and return the selected byte. A byte write becomes a read-modify-write of the whole word. The fetched word is repaired first, the new byte is merged in, and the check bits are recomputed before the word goes back. Any latent single-bit fault in that word is therefore cleaned up by the write.

The error code is invisible at the byte port: callers see plain bytes. A one-cycle pulse reports each repair. The wrapper also counts writes per word, since any byte write rewrites the whole word. The counter stops at its maximum value, and a flag shows when the count of the word just written has reached a limit set on an input port. The storage array is outside the block: it is any synchronous RAM with one cycle of read latency, one word per group index, driven through the mem_* ports.

One request is handled at a time. The block takes a request when `req` is high and `busy` is low. `busy` then stays high until the operation is complete, and requests made during that time are dropped.

Top module: `grp_ecc_mem`

## Requirements
- R1: The bytes at addresses 4N, 4N+1, 4N+2 and 4N+3 share stored word N. On every access `mem_addr` equals `addr >> 2`.
- R2: A read taken at clock edge E gives `rd_valid` high for exactly one cycle after edge E+2. `rd_data` is then byte lane `addr[1:0]` of the stored data, where lane k is data bits 8k+7:8k.
- R3: A read returns the correct byte when any one of the 38 stored bits of the word (data or check) is flipped.
- R4: `corr_pulse` is high for one cycle, aligned with `rd_valid` on a read or with `mem_we` on a write, exactly when a bit was repaired. It is low on clean accesses.
- R5: A byte write taken at edge E asserts `mem_we` for exactly the cycle between edges E+2 and E+3. It stores a valid codeword in which only the addressed lane changed.
- R6: A byte write to a word holding a single-bit fault raises `corr_pulse` and leaves the word fault-free. A read alone does not remove the fault, so repeated reads keep reporting it.
- R7: `busy` is high from the edge that takes a request until the operation ends: 2 cycles for a read, 3 for a write. A request made while `busy` is high is ignored.
- R8: Each word has its own write counter, incremented by a write to any of its four bytes. After edge E+3 of a write, `wear_cnt` shows the new count of the written word.
- R9: A word's write counter saturates at 2^CNT_W-1 instead of wrapping.
- R10: `wear_hit` is updated together with `wear_cnt` and is high exactly when the new count is greater than or equal to `cyc_limit`.
- R11: After reset, `busy`, `rd_valid`, `corr_pulse`, `mem_we`, `wear_cnt` and `wear_hit` are 0, and every write counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request strobe, taken when busy is low |
| we | input | 1 | 1 = byte write, 0 = byte read |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Byte to write |
| cyc_limit | input | CNT_W | Write-count threshold for wear_hit |
| busy | output | 1 | Operation in progress |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | 8 | Byte returned by a read |
| corr_pulse | output | 1 | One-cycle pulse: a single-bit error was repaired |
| wear_cnt | output | CNT_W | Write count of the word last written |
| wear_hit | output | 1 | wear_cnt has reached cyc_limit |
| mem_addr | output | ADDR_W-2 | Word index to the storage array |
| mem_we | output | 1 | Storage write enable |
| mem_wdata | output | 38 | Encoded word to store |
| mem_rdata | input | 38 | Encoded word read, one cycle after mem_addr |

## Verification
The hardest case to reach from the byte port is a stored word that holds a single flipped bit. Every write through the port stores a clean codeword, so such a word never arises from port traffic alone. The bench therefore owns the synchronous RAM on the mem_* side and inverts chosen bits in it directly. It covers all 38 bit positions, checks bits included. It then shows that repeated reads keep reporting the fault, and that a write to a neighbouring byte of the same word repairs it for good.

// File: rtl/grp_ecc_pkg.sv
// Package: shared constants, controller state type and the single-error
// correcting code over one 32-bit word. Codeword bit p-1 holds Hamming
// position p (1..38); positions 1,2,4,8,16,32 carry check bits.
package grp_ecc_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int DATA_W = BYTE_W * LANES;
    localparam int PAR_W  = 6;
    localparam int CW_W   = DATA_W + PAR_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_STORE
    } ctl_state_t;

    // XOR of the positions of all set bits; zero for a valid codeword.
    function automatic logic [PAR_W-1:0] hm_syndrome(input logic [CW_W-1:0] cw);
        logic [PAR_W-1:0] s;
        s = '0;
        for (int p = 1; p <= CW_W; p++) begin
            if (cw[p-1]) s = s ^ PAR_W'(p);
        end
        return s;
    endfunction

    // Spread the data over non-power-of-two positions, then set check bits.
    function automatic logic [CW_W-1:0] hm_encode(input logic [DATA_W-1:0] d);
        logic [CW_W-1:0]  cw;
        logic [PAR_W-1:0] s;
        int j;
        cw = '0;
        j  = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p-1] = d[j];
                j++;
            end
        end
        s = hm_syndrome(cw);
        for (int k = 0; k < PAR_W; k++) cw[(1 << k) - 1] = s[k];
        return cw;
    endfunction

    // Gather the data bits back out of a codeword.
    function automatic logic [DATA_W-1:0] hm_extract(input logic [CW_W-1:0] cw);
        logic [DATA_W-1:0] d;
        int j;
        d = '0;
        j = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[j] = cw[p-1];
                j++;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/grp_ecc_dec.sv
// Module: grp_ecc_dec
// Combinational single-error corrector. Computes the syndrome of a fetched
// codeword, flips the indicated bit and returns the 32 data bits.
// Assumes at most one bit in error; a double error is miscorrected.
module grp_ecc_dec
    import grp_ecc_pkg::*;
(
    input  logic [CW_W-1:0]   cw_i,
    output logic [DATA_W-1:0] data_o,
    output logic              fixed_o
);

    logic [PAR_W-1:0] syn;
    logic [CW_W-1:0]  repaired;

    // Locate and flip the faulty bit, then strip the check bits.
    always_comb begin
        syn      = hm_syndrome(cw_i);
        fixed_o  = (syn != '0);
        repaired = cw_i;
        if (syn != '0 && syn <= PAR_W'(CW_W))
            repaired = cw_i ^ ({{(CW_W-1){1'b0}}, 1'b1} << (syn - 1'b1));
        data_o = hm_extract(repaired);
    end

    // R3: the repaired word must be a valid codeword
    always_comb begin
        if (!$isunknown(cw_i))
            a_repair_clean_r3: assert (hm_syndrome(repaired) == '0 || syn > PAR_W'(CW_W));
    end

endmodule

// File: rtl/grp_lane_merge.sv
// Module: grp_lane_merge
// Replaces one byte lane of a 32-bit word with a new byte; the other
// lanes pass through. Lane k is bits 8k+7:8k.
module grp_lane_merge
    import grp_ecc_pkg::*;
(
    input  logic [DATA_W-1:0] word_i,
    input  logic [1:0]        lane_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [DATA_W-1:0] word_o
);

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            // Select the new byte for the addressed lane only.
            assign word_o[g*BYTE_W +: BYTE_W] =
                (lane_i == 2'(g)) ? byte_i : word_i[g*BYTE_W +: BYTE_W];
        end
    endgenerate

endmodule

// File: rtl/grp_wear_ctr.sv
// Module: grp_wear_ctr
// Per-word write counters, saturating at all-ones. On a bump it reports the
// new count of the bumped word and whether it has reached the limit.
// Assumes one bump per cycle at most.
module grp_wear_ctr #(
    parameter int NGRP  = 64,
    parameter int CNT_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bump_i,
    input  logic [$clog2(NGRP)-1:0] grp_i,
    input  logic [CNT_W-1:0]        limit_i,
    output logic [CNT_W-1:0]        cnt_o,
    output logic                    hit_o
);

    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [CNT_W-1:0] cnt_q [NGRP];
    logic [CNT_W-1:0] nxt;

    // Next count for the addressed word, held at the ceiling.
    always_comb begin
        nxt = (cnt_q[grp_i] == CMAX) ? CMAX : cnt_q[grp_i] + 1'b1;
    end

    // Counter storage and reported values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NGRP; i++) cnt_q[i] <= '0;
            cnt_o <= '0;
            hit_o <= 1'b0;
        end else if (bump_i) begin
            cnt_q[grp_i] <= nxt;
            cnt_o        <= nxt;
            hit_o        <= (nxt >= limit_i);
        end
    end

    p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bump_i && cnt_q[grp_i] == CMAX |=> cnt_o == CMAX);

    p_increment_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bump_i && cnt_q[grp_i] != CMAX |=> cnt_o == $past(cnt_q[grp_i]) + 1'b1);

    p_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bump_i |=> hit_o == (cnt_o >= $past(limit_i)));

endmodule

// File: rtl/grp_ecc_mem.sv
// Module: grp_ecc_mem (top)
// Byte port onto a word-organised array with single-error correction per
// 32-bit word. Reads fetch, repair and select a byte; writes repair, merge,
// re-encode and store the whole word, and bump that word's write counter.
// Assumes an external synchronous RAM with one cycle of read latency.
module grp_ecc_mem
    import grp_ecc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [CNT_W-1:0]  cyc_limit,
    output logic              busy,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              corr_pulse,
    output logic [CNT_W-1:0]  wear_cnt,
    output logic              wear_hit,
    output logic [ADDR_W-3:0] mem_addr,
    output logic              mem_we,
    output logic [37:0]       mem_wdata,
    input  logic [37:0]       mem_rdata
);

    localparam int GRP_W = ADDR_W - 2;
    localparam int NGRP  = 1 << GRP_W;

    ctl_state_t        state;
    logic              we_q;
    logic [1:0]        lane_q;
    logic [GRP_W-1:0]  grp_q;
    logic [BYTE_W-1:0] byte_q;
    logic [DATA_W-1:0] merged_q;
    logic [DATA_W-1:0] dec_data;
    logic [DATA_W-1:0] merged;
    logic              dec_fixed;
    logic              take;

    assign take      = req && (state == ST_IDLE);
    assign busy      = (state != ST_IDLE);
    assign mem_addr  = grp_q;
    assign mem_we    = (state == ST_STORE);
    assign mem_wdata = hm_encode(merged_q);

    grp_ecc_dec u_dec (
        .cw_i    (mem_rdata),
        .data_o  (dec_data),
        .fixed_o (dec_fixed)
    );

    grp_lane_merge u_merge (
        .word_i (dec_data),
        .lane_i (lane_q),
        .byte_i (byte_q),
        .word_o (merged)
    );

    grp_wear_ctr #(.NGRP(NGRP), .CNT_W(CNT_W)) u_wear (
        .clk     (clk),
        .rst_n   (rst_n),
        .bump_i  (mem_we),
        .grp_i   (grp_q),
        .limit_i (cyc_limit),
        .cnt_o   (wear_cnt),
        .hit_o   (wear_hit)
    );

    // Sequence: take request, issue fetch, check/merge, optional store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (take) state <= ST_FETCH;
                ST_FETCH: state <= ST_CHECK;
                ST_CHECK: state <= we_q ? ST_STORE : ST_IDLE;
                ST_STORE: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Latch the request fields when it is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q   <= 1'b0;
            lane_q <= '0;
            grp_q  <= '0;
            byte_q <= '0;
        end else if (take) begin
            we_q   <= we;
            lane_q <= addr[1:0];
            grp_q  <= addr[ADDR_W-1:2];
            byte_q <= wdata;
        end
    end

    // Result registers: read byte, strobes and the merged word to store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            corr_pulse <= 1'b0;
            merged_q   <= '0;
        end else begin
            rd_valid   <= 1'b0;
            corr_pulse <= 1'b0;
            if (state == ST_CHECK) begin
                corr_pulse <= dec_fixed;
                merged_q   <= merged;
                if (!we_q) begin
                    rd_valid <= 1'b1;
                    rd_data  <= dec_data[lane_q*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    p_rdv_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_corr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        corr_pulse |=> !corr_pulse);

    p_corr_ctx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        corr_pulse |-> (rd_valid || mem_we));

    p_one_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    p_store_codeword_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> hm_syndrome(mem_wdata) == '0);

    p_store_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !busy);

    p_rdv_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !busy);

    p_hold_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !mem_we |=> $stable(mem_addr));

endmodule

// File: tb/test_grp_ecc_mem.sv
`timescale 1ns/1ps
module test_grp_ecc_mem;

    localparam int ADDR_W = 8;
    localparam int CNT_W  = 4;
    localparam int NG     = 1 << (ADDR_W - 2);
    localparam int CMAXV  = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic              we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic [CNT_W-1:0]  lim = '1;
    logic              busy, rd_valid, corr_pulse, wear_hit, mem_we;
    logic [7:0]        rd_data;
    logic [CNT_W-1:0]  wear_cnt;
    logic [ADDR_W-3:0] mem_addr;
    logic [37:0]       mem_wdata;
    logic [37:0]       mem_rdata;

    logic [37:0] ram [NG];
    logic [7:0]  exp_mem [1 << ADDR_W];
    int          exp_wear [NG];
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    // Storage array: one-cycle read latency, write on mem_we.
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        mem_rdata <= ram[mem_addr];
    end

    grp_ecc_mem #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_grp_ecc_mem (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .cyc_limit(lim), .busy(busy), .rd_valid(rd_valid),
        .rd_data(rd_data), .corr_pulse(corr_pulse), .wear_cnt(wear_cnt),
        .wear_hit(wear_hit), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One read with exact-cycle checks; expected corr flag supplied by caller.
    task automatic do_read(input int a, input bit exp_corr);
        @(negedge clk);
        req = 1; we = 0; addr = ADDR_W'(a);
        @(negedge clk);                 // after accept edge
        req = 0;
        @(negedge clk);
        chk(busy == 1, "R7 busy during read", int'(busy), 1);
        @(negedge clk);
        chk(rd_valid == 1, "R2 rd_valid timing", int'(rd_valid), 1);
        chk(rd_data == exp_mem[a], "R2/R3 read data", int'(rd_data), int'(exp_mem[a]));
        chk(corr_pulse == exp_corr, "R4 corr on read", int'(corr_pulse), int'(exp_corr));
        chk(busy == 0, "R7 busy end read", int'(busy), 0);
        @(negedge clk);
        chk(rd_valid == 0 && corr_pulse == 0, "R2 one-cycle pulse", int'(rd_valid), 0);
    endtask

    // One byte write; optional intruding request held while busy.
    task automatic do_write(input int a, input int d, input bit exp_corr,
                            input bit intr, input int ia, input int id);
        int g;
        g = a >> 2;
        @(negedge clk);
        req = 1; we = 1; addr = ADDR_W'(a); wdata = 8'(d);
        @(negedge clk);
        req = intr; addr = ADDR_W'(ia); wdata = 8'(id);
        @(negedge clk);
        chk(busy == 1 && mem_we == 0, "R7 busy fetch", int'(mem_we), 0);
        @(negedge clk);
        chk(mem_we == 1, "R5 store cycle", int'(mem_we), 1);
        chk(int'(mem_addr) == g, "R1 word index", int'(mem_addr), g);
        chk(corr_pulse == exp_corr, "R4/R6 corr on write", int'(corr_pulse), int'(exp_corr));
        @(negedge clk);
        req = 0;
        exp_mem[a] = 8'(d);
        if (exp_wear[g] < CMAXV) exp_wear[g]++;
        chk(busy == 0 && mem_we == 0, "R5/R7 write ends", int'(busy), 0);
        chk(int'(wear_cnt) == exp_wear[g], "R8/R9 wear count", int'(wear_cnt), exp_wear[g]);
        chk(wear_hit == (exp_wear[g] >= int'(lim)), "R10 wear hit", int'(wear_hit),
            int'(exp_wear[g] >= int'(lim)));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(busy == 0 && rd_valid == 0 && corr_pulse == 0, "R11 reset strobes", int'(busy), 0);
        chk(mem_we == 0 && wear_cnt == 0 && wear_hit == 0, "R11 reset wear", int'(wear_cnt), 0);
    endtask

    // R1 R2 R5: fill one word lane by lane, neighbours unchanged.
    task automatic t_lanes;
        do_write(20, 8'h11, 0, 0, 0, 0);
        do_write(21, 8'hA2, 0, 0, 0, 0);
        do_write(22, 8'h5C, 0, 0, 0, 0);
        do_write(23, 8'hF0, 0, 0, 0, 0);
        do_write(25, 8'h77, 0, 0, 0, 0);
        for (int a = 20; a < 28; a++) do_read(a, 0);
        do_write(22, 8'h00, 0, 0, 0, 0);
        for (int a = 20; a < 24; a++) do_read(a, 0);
    endtask

    // R3 R4 R6: every one of the 38 stored bits, read twice then restored.
    task automatic t_correct;
        for (int b = 0; b < 38; b++) begin
            @(negedge clk);
            ram[5][b] = ~ram[5][b];
            do_read(20 + (b % 4), 1);
            do_read(20 + ((b + 1) % 4), 1);   // R6: a read does not scrub
            @(negedge clk);
            ram[5][b] = ~ram[5][b];
        end
        do_read(21, 0);
    endtask

    // R6: a write repairs the latent fault in its word.
    task automatic t_scrub;
        @(negedge clk);
        ram[5][13] = ~ram[5][13];
        do_write(23, 8'h3B, 1, 0, 0, 0);
        for (int a = 20; a < 24; a++) do_read(a, 0);
        @(negedge clk);
        ram[5][36] = ~ram[5][36];
        do_write(20, 8'hC4, 1, 0, 0, 0);
        do_read(20, 0);
        do_read(22, 0);
    endtask

    // R7: a request held during a write is dropped.
    task automatic t_busy;
        do_write(60, 8'h9D, 0, 0, 0, 0);
        do_write(8, 8'h42, 0, 1, 60, 8'hEE);
        do_read(60, 0);
        do_read(8, 0);
    endtask

    // R8 R9 R10: shared counting per word, saturation, threshold.
    task automatic t_wear;
        lim = 4'd5;
        for (int i = 0; i < 20; i++) do_write(40 + (i % 4), i, 0, 0, 0, 0);
        do_write(44, 8'h01, 0, 0, 0, 0);
        lim = 4'd1;
        do_write(45, 8'h02, 0, 0, 0, 0);
        lim = 4'd3;
        do_write(46, 8'h03, 0, 0, 0, 0);
        do_read(42, 0);
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        for (int g = 0; g < NG; g++) begin
            ram[g] = '0;
            exp_wear[g] = 0;
        end
        for (int a = 0; a < (1 << ADDR_W); a++) exp_mem[a] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_lanes();
        t_correct();
        t_scrub();
        t_busy();
        t_wear();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

endmodule